// File: doc/BRIEF.md
# Far-End Alarm Codeword Controller

This block runs the far-end alarm and control channel of a DS3 C-bit framed line. The channel carries one bit per frame, and the framer signals that bit slot with a single-cycle `slot_en` pulse. On the transmit side, a host command carries a 6-bit code and a mode. The controller turns the code into 16-bit codewords and sends them:

- once, as ten copies;
- continuously, until told to stop;
- or as a pair of two different codes, ten copies of each in turn, which is how line loopback requests are signalled.

On the receive side, the controller hunts the incoming channel bits for codewords. It accepts a code only when it repeats, and it queues each newly accepted code in a four-entry queue. Several codes arriving in succession need no host action.

Commands enter on a valid/ready handshake. `tx_valid` with its mode and codes must stay stable until a cycle in which `tx_ready` is high. A command offered while `tx_ready` is low is not taken. Received codes leave on a valid/ready handshake: `rx_valid` and `rx_code` hold until `rx_ready` takes the entry. The line itself cannot be stalled. A code accepted while the queue is full is lost, and this is flagged.

Top module: `feac_ctrl`

## Requirements
- R1: A codeword goes out on `tx_bit` as eight 1s, then a 0, then the six code bits starting with code bit 0, then a 0. Each bit is held for one `slot_en` pulse.
- R2: After reset, `tx_bit` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rx_overflow` is 0. While no command is running, `tx_bit` stays 1.
- R3: Both channel directions move one bit only on a clock with `slot_en` high. Without `slot_en`, `tx_bit` does not change and no new code is queued.
- R4: In mode 0 (and mode 3, which behaves the same), the code is sent as exactly ten codewords. After the tenth, the block returns to idle with `tx_ready` high.
- R5: In mode 1, the codeword repeats without limit. A `tx_stop` pulse ends the run at the end of the codeword in progress, so no codeword is ever cut short.
- R6: In mode 2, ten codewords of `tx_code_a` are followed directly by ten codewords of `tx_code_b`, and then the block goes idle.
- R7: `tx_ready` is low from the clock after a command is taken until the run ends. A `tx_valid` offered during a run has no effect on what is sent.
- R8: The receiver finds a codeword at any bit position and aligns to it. Without a match, it closes a 16-bit slot every 16 channel bits.
- R9: A code is accepted when at least 8 of the last 10 receive slots held a valid codeword carrying that code. It is queued only if it differs from the last accepted code, or if the receiver was idle. The receiver becomes idle after 10 slots with no valid codeword.
- R10: Accepted codes leave the queue oldest first, up to 4 held. `rx_valid` rises on the clock after the `slot_en` that carried the last bit of the accepting codeword, when the queue was empty.
- R11: A code accepted while the queue holds 4 entries and none is leaving is dropped. It also sets `rx_overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One pulse per frame: the channel bit slot |
| tx_valid | input | 1 | Transmit command offered |
| tx_ready | output | 1 | Transmitter idle, command can be taken |
| tx_mode | input | 2 | 0 once, 1 continuous, 2 pair, 3 once |
| tx_code_a | input | 6 | Code sent first (or only) |
| tx_code_b | input | 6 | Second code in pair mode |
| tx_stop | input | 1 | Ends a continuous run at the next codeword end |
| tx_bit | output | 1 | Outgoing channel bit |
| rx_bit | input | 1 | Incoming channel bit, sampled with slot_en |
| rx_valid | output | 1 | Queue holds a code |
| rx_ready | input | 1 | Consumer takes the head code |
| rx_code | output | 6 | Code at the queue head |
| rx_overflow | output | 1 | Sticky: an accepted code was dropped |

## Verification
The hardest state to reach is overflow. It needs five distinct accepted codes while the consumer stalls, and every code costs about eight repetitions on a one-bit-per-frame channel. The stimulus loops the transmitter into the receiver with `rx_ready` held low. It then issues two pair commands and a single command back to back. Because each code differs from the last, every one is queued without an idle gap. Misaligned reception with some corrupted repetitions comes from a bench-driven bit stream that starts mid-pattern.

// File: rtl/feac_pkg.sv
package feac_pkg;

  localparam int CODE_W = 6;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    TXM_ONCE  = 2'd0,
    TXM_LOOP  = 2'd1,
    TXM_PAIR  = 2'd2,
    TXM_ONCE3 = 2'd3
  } tx_mode_e;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } rx_slot_t;

  // Bit 15 leaves first: 8 ones, 0, code[0]..code[5], 0
  function automatic logic [WORD_W-1:0] feac_word(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = 16'hFF00;
    for (int i = 0; i < CODE_W; i++) w[6-i] = c[i];
    return w;
  endfunction

  // field holds word bits 6..1 (code bit 0 sits in the top position)
  function automatic logic [CODE_W-1:0] feac_field_to_code(input logic [CODE_W-1:0] f);
    logic [CODE_W-1:0] c;
    for (int i = 0; i < CODE_W; i++) c[i] = f[CODE_W-1-i];
    return c;
  endfunction

endpackage

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [CODE_W-1:0] cmd_code_a,
  input  logic [CODE_W-1:0] cmd_code_b,
  input  logic              stop_req,
  output logic              line_bit
);

  localparam int REP_W = $clog2(REPEAT + 1);
  localparam int IDX_W = $clog2(WORD_W);

  logic              busy;
  tx_mode_e          mode_q;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic              on_b;
  logic [REP_W-1:0]  rep;
  logic [IDX_W-1:0]  idx;
  logic              stop_pend;

  logic [CODE_W-1:0] cur_code;
  logic [WORD_W-1:0] cur_word;
  logic              word_end, last_rep;

  assign cur_code  = on_b ? code_b_q : code_a_q;
  assign cur_word  = feac_word(cur_code);
  assign line_bit  = busy ? cur_word[IDX_W'(WORD_W-1) - idx] : 1'b1;
  assign cmd_ready = !busy;
  assign word_end  = busy && slot_en && (idx == IDX_W'(WORD_W-1));
  assign last_rep  = (rep == REP_W'(REPEAT-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= TXM_ONCE;
      code_a_q  <= '0;
      code_b_q  <= '0;
      on_b      <= 1'b0;
      rep       <= '0;
      idx       <= '0;
      stop_pend <= 1'b0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy      <= 1'b1;
        mode_q    <= tx_mode_e'(cmd_mode);
        code_a_q  <= cmd_code_a;
        code_b_q  <= cmd_code_b;
        on_b      <= 1'b0;
        rep       <= '0;
        idx       <= '0;
        stop_pend <= 1'b0;
      end
    end else begin
      if (stop_req) stop_pend <= 1'b1;
      if (slot_en) idx <= idx + 1'b1;
      if (word_end) begin
        unique case (mode_q)
          TXM_LOOP: begin
            if (stop_pend || stop_req) busy <= 1'b0;
          end
          TXM_PAIR: begin
            if (!last_rep) rep <= rep + 1'b1;
            else if (!on_b) begin
              on_b <= 1'b1;
              rep  <= '0;
            end else busy <= 1'b0;
          end
          default: begin
            if (!last_rep) rep <= rep + 1'b1;
            else busy <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/feac_rx.sv
module feac_rx
  import feac_pkg::*;
#(
  parameter int HIST = 10,
  parameter int NEED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              line_bit,
  output logic              push_valid,
  output logic [CODE_W-1:0] push_code
);

  localparam int OLD   = HIST - 1;
  localparam int CNT_W = $clog2(HIST + 1);
  localparam int PH_W  = $clog2(WORD_W);

  logic [WORD_W-2:0] win;
  logic [WORD_W-1:0] win_n;
  logic [PH_W-1:0]   phase;
  rx_slot_t          hist   [OLD];
  rx_slot_t          hist_n [HIST];
  logic              active;
  logic [CODE_W-1:0] last;

  logic [CODE_W-1:0] cand;
  logic              hit, slot_close, accept;
  logic [CNT_W-1:0]  agree;
  logic              any_ok;

  assign win_n      = {win, line_bit};
  assign cand       = feac_field_to_code(win_n[6:1]);
  assign hit        = (win_n == feac_word(cand));
  assign slot_close = slot_en && (hit || phase == PH_W'(WORD_W-1));

  assign hist_n[0] = {hit, cand};
  for (genvar g = 1; g < HIST; g++) begin : g_hist
    assign hist_n[g] = hist[g-1];
  end

  always_comb begin
    agree  = '0;
    any_ok = 1'b0;
    for (int i = 0; i < HIST; i++) begin
      if (hist_n[i].ok && hist_n[i].code == cand) agree = agree + 1'b1;
      any_ok = any_ok | hist_n[i].ok;
    end
  end

  assign accept     = slot_close && hit && (agree >= CNT_W'(NEED));
  assign push_valid = accept && (!active || cand != last);
  assign push_code  = cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win    <= '1;
      phase  <= '0;
      active <= 1'b0;
      last   <= '0;
      for (int i = 0; i < OLD; i++) hist[i] <= '0;
    end else if (slot_en) begin
      win   <= win_n[WORD_W-2:0];
      phase <= slot_close ? '0 : phase + 1'b1;
      if (slot_close) begin
        for (int i = 0; i < OLD; i++) hist[i] <= hist_n[i];
        if (accept) begin
          active <= 1'b1;
          last   <= cand;
        end else if (!any_ok) begin
          active <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/feac_fifo.sv
module feac_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, pop, do_wr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign pop      = rd_valid && rd_ready;
  assign do_wr    = wr_en && (!full || pop);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wp <= step(wp);
      if (pop)   rp <= step(rp);
      if (do_wr && !pop)      cnt <= cnt + 1'b1;
      else if (!do_wr && pop) cnt <= cnt - 1'b1;
      if (wr_en && !do_wr) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/feac_ctrl.sv
module feac_ctrl
  import feac_pkg::*;
#(
  parameter int TX_REPEAT = 10,
  parameter int RX_WINDOW = 10,
  parameter int RX_NEED   = 8,
  parameter int Q_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [1:0]        tx_mode,
  input  logic [CODE_W-1:0] tx_code_a,
  input  logic [CODE_W-1:0] tx_code_b,
  input  logic              tx_stop,
  output logic              tx_bit,
  input  logic              rx_bit,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_overflow
);

  logic              acc_valid;
  logic [CODE_W-1:0] acc_code;

  feac_tx #(.REPEAT(TX_REPEAT)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_en    (slot_en),
    .cmd_valid  (tx_valid),
    .cmd_ready  (tx_ready),
    .cmd_mode   (tx_mode),
    .cmd_code_a (tx_code_a),
    .cmd_code_b (tx_code_b),
    .stop_req   (tx_stop),
    .line_bit   (tx_bit)
  );

  feac_rx #(.HIST(RX_WINDOW), .NEED(RX_NEED)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_en    (slot_en),
    .line_bit   (rx_bit),
    .push_valid (acc_valid),
    .push_code  (acc_code)
  );

  feac_fifo #(.DEPTH(Q_DEPTH), .W(CODE_W)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_valid),
    .wr_data  (acc_code),
    .rd_valid (rx_valid),
    .rd_ready (rx_ready),
    .rd_data  (rx_code),
    .overflow (rx_overflow)
  );

endmodule

// File: rtl/feac_ctrl_chk.sv
module feac_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_bit,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [5:0] rx_code,
  input logic       rx_overflow
);

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en && !(tx_valid && tx_ready)) |=> $stable(tx_bit));

  p_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en && !rx_valid) |=> !rx_valid);

  p_done_on_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(slot_en));

  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_code)));

  p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

endmodule

bind feac_ctrl feac_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_en     (slot_en),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_bit      (tx_bit),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_code     (rx_code),
  .rx_overflow (rx_overflow)
);

// File: tb/feac_ctrl_test.sv
`timescale 1ns/1ps
module feac_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [1:0] tx_mode = 2'd0;
  logic [5:0] tx_code_a = 6'd0;
  logic [5:0] tx_code_b = 6'd0;
  logic       tx_stop = 1'b0;
  logic       rx_ready = 1'b0;
  logic       ext_bit = 1'b1;
  logic       loop_sel = 1'b1;
  logic       gen_on = 1'b0;
  logic       cap_on = 1'b0;
  logic       tx_ready, tx_bit, rx_valid, rx_overflow, rx_bit;
  logic [5:0] rx_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int div = 3;
  int divc = 0;
  bit extq[$];
  bit cap[$];
  int got[$];

  assign rx_bit = loop_sel ? tx_bit : ext_bit;

  always #2 clk = ~clk;

  feac_ctrl uut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_mode(tx_mode),
    .tx_code_a(tx_code_a), .tx_code_b(tx_code_b), .tx_stop(tx_stop),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_code(rx_code), .rx_overflow(rx_overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- slot generator / external bit source ----------------
  always @(negedge clk) begin
    if (gen_on) begin
      if (divc == 0) begin
        slot_en <= 1'b1;
        if (extq.size() > 0) ext_bit <= extq.pop_front();
        else ext_bit <= 1'b1;
      end else slot_en <= 1'b0;
      divc <= (divc + 1) % div;
    end else slot_en <= 1'b0;
  end

  // ---------------- behavioural reference model ----------------
  bit m_txq[$];
  bit m_ready, m_cont, m_stopf;
  int m_ccode;
  int m_win, m_phase;
  int m_hok[$];
  int m_hcode[$];
  bit m_active;
  int m_last;
  int m_fq[$];
  bit m_ovf;

  function automatic void add_word(int c);
    for (int i = 0; i < 8; i++) m_txq.push_back(1'b1);
    m_txq.push_back(1'b0);
    for (int i = 0; i < 6; i++) m_txq.push_back(bit'((c >> i) & 1));
    m_txq.push_back(1'b0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txq.delete(); m_ready = 1; m_cont = 0; m_stopf = 0; m_ccode = 0;
      m_win = 'hFFFF; m_phase = 0; m_hok.delete(); m_hcode.delete();
      m_active = 0; m_last = 0; m_fq.delete(); m_ovf = 0;
    end else begin
      bit txb, inb, ok, bnd;
      int c, cnt, anyv;
      txb = (m_txq.size() > 0) ? m_txq[0] : 1'b1;
      inb = loop_sel ? txb : ext_bit;
      if (rx_ready && m_fq.size() > 0) void'(m_fq.pop_front());
      if (slot_en) begin
        m_win = ((m_win << 1) | int'(inb)) & 'hFFFF;
        ok = ((m_win >> 8) == 'hFF) && (((m_win >> 7) & 1) == 0) && ((m_win & 1) == 0);
        c = 0;
        for (int i = 0; i < 6; i++) c |= ((m_win >> (6 - i)) & 1) << i;
        bnd = ok || (m_phase == 15);
        m_phase = bnd ? 0 : m_phase + 1;
        if (bnd) begin
          m_hok.push_front(int'(ok)); m_hcode.push_front(c);
          if (m_hok.size() > 10) begin void'(m_hok.pop_back()); void'(m_hcode.pop_back()); end
          cnt = 0; anyv = 0;
          foreach (m_hok[i]) begin
            if (m_hok[i] != 0 && m_hcode[i] == c) cnt++;
            if (m_hok[i] != 0) anyv = 1;
          end
          if (ok && cnt >= 8) begin
            if (!m_active || c != m_last) begin
              if (m_fq.size() < 4) m_fq.push_back(c); else m_ovf = 1;
            end
            m_active = 1; m_last = c;
          end else if (anyv == 0) m_active = 0;
        end
      end
      if (tx_stop && !m_ready && m_cont) m_stopf = 1;
      if (tx_valid && m_ready) begin
        m_ready = 0; m_stopf = 0;
        m_cont = (tx_mode == 2'd1);
        m_ccode = int'(tx_code_a);
        if (m_cont) add_word(m_ccode);
        else begin
          for (int k = 0; k < 10; k++) add_word(int'(tx_code_a));
          if (tx_mode == 2'd2) for (int k = 0; k < 10; k++) add_word(int'(tx_code_b));
        end
      end else if (slot_en && !m_ready) begin
        void'(m_txq.pop_front());
        if (m_txq.size() == 0) begin
          if (m_cont && !m_stopf) add_word(m_ccode);
          else m_ready = 1;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      chk(tx_bit === ((m_txq.size() > 0) ? m_txq[0] : 1'b1), "R1 tx_bit",
          int'(tx_bit), int'((m_txq.size() > 0) ? m_txq[0] : 1'b1));
      chk(tx_ready === m_ready, "R7 tx_ready", int'(tx_ready), int'(m_ready));
      chk(rx_valid === (m_fq.size() > 0), "R10 rx_valid", int'(rx_valid), int'(m_fq.size() > 0));
      if (m_fq.size() > 0) chk(int'(rx_code) == m_fq[0], "R9 rx_code", int'(rx_code), m_fq[0]);
      chk(rx_overflow === m_ovf, "R11 rx_overflow", int'(rx_overflow), int'(m_ovf));
      if (rx_valid && rx_ready) got.push_back(int'(rx_code));
      if (cap_on && slot_en) cap.push_back(tx_bit);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R2 actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_ready();
    do @(negedge clk); while (!tx_ready);
  endtask

  task automatic send(input logic [1:0] m, input logic [5:0] a, input logic [5:0] b, input bit capture);
    wait_ready();
    tx_mode = m; tx_code_a = a; tx_code_b = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (capture) begin cap.delete(); cap_on = 1'b1; end
  endtask

  task automatic idle_words(input int n);
    repeat (n * 16 * div) @(negedge clk);
  endtask

  function automatic int word_at(int off);
    int c;
    if (off + 16 > cap.size()) return -1;
    for (int i = 0; i < 8; i++) if (cap[off + i] != 1'b1) return -1;
    if (cap[off + 8] != 1'b0 || cap[off + 15] != 1'b0) return -1;
    c = 0;
    for (int i = 0; i < 6; i++) c |= int'(cap[off + 9 + i]) << i;
    return c;
  endfunction

  function automatic int count_words(int code, int from, int n);
    int k = 0;
    for (int w = from; w < from + n; w++) if (word_at(w * 16) == code) k++;
    return k;
  endfunction

  task automatic ext_word(input int c);
    for (int i = 0; i < 8; i++) extq.push_back(1'b1);
    extq.push_back(1'b0);
    for (int i = 0; i < 6; i++) extq.push_back(bit'((c >> i) & 1));
    extq.push_back(1'b0);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int held, gs;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_bit === 1'b1, "R2 reset tx_bit", int'(tx_bit), 1);
    chk(tx_ready === 1'b1, "R2 reset tx_ready", int'(tx_ready), 1);
    chk(rx_valid === 1'b0, "R2 reset rx_valid", int'(rx_valid), 0);
    chk(rx_overflow === 1'b0, "R2 reset rx_overflow", int'(rx_overflow), 0);
    gen_on = 1'b1;
    rx_ready = 1'b1;

    // R1 / R4: single mode
    send(2'd0, 6'h25, 6'h00, 1);
    wait_ready(); cap_on = 1'b0;
    chk(word_at(0) == 'h25, "R1 codeword layout", word_at(0), 'h25);
    chk(cap.size() == 160, "R4 single length bits", cap.size(), 160);
    chk(count_words('h25, 0, 10) == 10, "R4 single ten copies", count_words('h25, 0, 10), 10);
    idle_words(12);
    chk(got.size() == 1 && got[0] == 'h25, "R9 single accepted", (got.size() > 0) ? got[0] : -1, 'h25);

    // R6: pair mode, then R9 repeat of the last code is not queued again
    send(2'd2, 6'h12, 6'h2B, 1);
    wait_ready(); cap_on = 1'b0;
    chk(count_words('h12, 0, 10) == 10, "R6 first code x10", count_words('h12, 0, 10), 10);
    chk(count_words('h2B, 10, 10) == 10 && cap.size() == 320, "R6 second code x10",
        count_words('h2B, 10, 10), 10);
    send(2'd0, 6'h2B, 6'h00, 0);
    wait_ready();
    idle_words(12);
    chk(got.size() == 3, "R9 no duplicate push", got.size(), 3);
    chk(got[1] == 'h12 && got[2] == 'h2B, "R9 pair order", got[2], 'h2B);

    // R4: mode 3 behaves as once
    send(2'd3, 6'h01, 6'h3E, 1);
    wait_ready(); cap_on = 1'b0;
    chk(cap.size() == 160 && count_words('h01, 0, 10) == 10, "R4 mode3 once", cap.size(), 160);
    idle_words(12);

    // R5: continuous with stop mid-word
    send(2'd1, 6'h3F, 6'h00, 1);
    repeat (25 * 16 * 3 + 20) @(negedge clk);
    tx_stop = 1'b1;
    @(negedge clk);
    tx_stop = 1'b0;
    wait_ready(); cap_on = 1'b0;
    chk(cap.size() % 16 == 0, "R5 stop on word boundary", cap.size() % 16, 0);
    chk(cap.size() > 160 && count_words('h3F, 0, cap.size() / 16) == cap.size() / 16,
        "R5 continuous repeats", cap.size() / 16, 26);
    idle_words(12);

    // R3 / R7: pause slots, offer a command while busy
    send(2'd0, 6'h0C, 6'h00, 1);
    repeat (20) @(negedge clk);
    gen_on = 1'b0;
    repeat (4) @(negedge clk);
    held = int'(tx_bit);
    tx_mode = 2'd1; tx_code_a = 6'h2A; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(int'(tx_bit) == held, "R3 line frozen without slot", int'(tx_bit), held);
    chk(tx_ready === 1'b0, "R7 still busy", int'(tx_ready), 0);
    gen_on = 1'b1;
    wait_ready(); cap_on = 1'b0;
    chk(cap.size() == 160 && count_words('h0C, 0, 10) == 10, "R7 busy offer ignored",
        count_words('h0C, 0, 10), 10);
    idle_words(12);
    gs = got.size();

    // R8: misaligned external stream with two foreign repeats
    loop_sel = 1'b0;
    extq.push_back(1'b0); extq.push_back(1'b1); extq.push_back(1'b1);
    extq.push_back(1'b0); extq.push_back(1'b1);
    for (int w = 0; w < 10; w++) ext_word((w == 2 || w == 6) ? 'h0B : 'h0A);
    while (extq.size() > 0) @(negedge clk);
    idle_words(12);
    loop_sel = 1'b1;
    chk(got.size() == gs + 1 && got[got.size() - 1] == 'h0A, "R8 aligned and accepted 8 of 10",
        got[got.size() - 1], 'h0A);

    // R11 / R10: overflow with stalled consumer
    gs = got.size();
    rx_ready = 1'b0;
    send(2'd2, 6'h31, 6'h32, 0);
    send(2'd2, 6'h33, 6'h34, 0);
    send(2'd0, 6'h35, 6'h00, 0);
    wait_ready();
    idle_words(12);
    chk(rx_overflow === 1'b1, "R11 overflow flagged", int'(rx_overflow), 1);
    chk(got.size() == gs, "R10 stall holds queue", got.size(), gs);
    rx_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(got.size() == gs + 4, "R11 fifth code dropped", got.size() - gs, 4);
    for (int i = 0; i < 4; i++)
      chk(got.size() > gs + i && got[gs + i] == 'h31 + i, "R10 oldest first",
          (got.size() > gs + i) ? got[gs + i] : -1, 'h31 + i);
    chk(rx_overflow === 1'b1, "R11 overflow sticky", int'(rx_overflow), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule